// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Acknowledge

This block gathers interrupt requests from N sources and serves them one at a time. Every source has a pending flag. The flags are ORed onto a single shared request line. A small acknowledge controller watches that line. When it sees a request and no acknowledge is in progress, it raises one grant. The grant enters the chain at source 0, which is the source nearest the controller, and moves outward source by source.

A source with a pending flag keeps the grant and blocks it from going further. A source with no pending flag passes the grant on to the next source. Only the source that holds the grant drives its vector constant onto the shared vector bus. One cycle after the grant rises, the controller latches that vector, pulses a valid strobe and clears the winner's pending flag. It then drops the grant and leaves it low through one idle gap cycle. Requests that are still pending are served in later acknowledge cycles. The index of a source in the chain is therefore its priority, and source N-1 is served last.

Top module: `irq_chain`

## Requirements
- R1: While rst_n is low and directly after it, every pending flag is clear, and shared_irq, grant_out, vec_valid and vec_out are all 0.
- R2: A one-cycle high on req_in[i] sets the pending flag of source i at that clock edge. shared_irq is the OR of all pending flags, so it is high in the cycle after the pulse.
- R3: The grant is raised at the first clock edge where shared_irq is high, no grant is active and the controller is not in its gap cycle. It appears first on grant_out[0].
- R4: grant_out[i+1] is high exactly when grant_out[i] is high and source i has no pending flag. A high grant_out[i] with no grant on grant_out[0] never occurs.
- R5: When several flags are pending, the source with the lowest index holds the grant. The grant_out pattern is then ones from bit 0 up to and including the winner's bit.
- R6: The clock edge after the grant rises captures the vector of the holding source. Source i's vector is vec_tbl[i*VW +: VW]. vec_out takes this value and vec_valid is high for exactly one cycle.
- R7: At capture only the winner's pending flag is cleared. The remaining requests are served in later acknowledge cycles in ascending index order. After the last one is served, shared_irq is low.
- R8: In the cycle where vec_valid is high and in the next cycle, grant_out is all zero.
- R9: vec_out changes only in a cycle where vec_valid is high. Otherwise it keeps the last captured vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_in | input | N | Per-source request pulse that sets the pending flag |
| vec_tbl | input | N*VW | Vector constants, one VW-bit field for each source |
| shared_irq | output | 1 | OR of all pending flags |
| grant_out | output | N | Grant arriving at each source along the chain |
| vec_out | output | VW | Last captured vector |
| vec_valid | output | 1 | One-cycle strobe when a vector is captured |

## Verification
Several internal faults have visible effects. A pending flag that is cleared wrongly causes a source to go unserved, or lets shared_irq stay high after the last capture. A broken link in the ripple shows up at once as a wrong grant_out pattern in the grant cycle. A wrong capture edge or a stuck gap state moves vec_valid off its expected cycle, and this is seen within two clocks of the grant. A wrong bus select shows up as a wrong vec_out value on that same strobe.

// File: rtl/irq_chain.sv
module irq_chain #(
  parameter int N  = 4,
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_in,
  input  logic [N*VW-1:0] vec_tbl,
  output logic          shared_irq,
  output logic [N-1:0]  grant_out,
  output logic [VW-1:0] vec_out,
  output logic          vec_valid
);

  logic [N-1:0] pend;
  logic [N-1:0] take;
  logic [N:0]   gin;
  logic [N:0][VW-1:0] part;
  logic gnt, gap, cap;

  assign shared_irq = |pend;
  assign gin[0]     = gnt;
  assign part[0]    = '0;

  for (genvar i = 0; i < N; i++) begin : g_link
    assign take[i]     = gin[i] & pend[i];
    assign gin[i+1]    = gin[i] & ~pend[i];
    assign part[i+1]   = part[i] | (take[i] ? vec_tbl[i*VW +: VW] : '0);
  end

  assign grant_out = gin[N-1:0];
  assign cap       = gnt & (|take);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= '0;
      gnt       <= 1'b0;
      gap       <= 1'b0;
      vec_out   <= '0;
      vec_valid <= 1'b0;
    end else begin
      pend      <= (pend & ~(cap ? take : '0)) | req_in;
      vec_valid <= cap;
      gap       <= cap;
      if (cap) vec_out <= part[N];
      if (gnt) gnt <= ~(cap | ~(|take));
      else if (!gap && shared_irq) gnt <= 1'b1;
    end
  end

endmodule

module irq_chain_chk #(
  parameter int N  = 4,
  parameter int VW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          shared_irq,
  input logic [N-1:0]  grant_out,
  input logic [VW-1:0] vec_out,
  input logic          vec_valid
);

  p_grant_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_out[0]) |-> $past(shared_irq));

  p_chain_root_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_out[0] |-> (grant_out == '0));

  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);

  p_valid_after_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(grant_out[0]));

  p_grant_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (grant_out == '0) ##1 (grant_out == '0));

  p_vec_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid |-> $stable(vec_out));

endmodule

bind irq_chain irq_chain_chk #(.N(N), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .shared_irq(shared_irq), .grant_out(grant_out),
  .vec_out(vec_out), .vec_valid(vec_valid)
);

// File: tb/irq_chain_bench.sv
`timescale 1ns/1ps
module irq_chain_bench;
  localparam int N = 4, VW = 8;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] req_in = '0;
  logic [N*VW-1:0] vec_tbl = {8'h4C, 8'h38, 8'h24, 8'h10};
  logic shared_irq, vec_valid;
  logic [N-1:0] grant_out;
  logic [VW-1:0] vec_out;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_chain #(.N(N), .VW(VW)) u_irq_chain (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .vec_tbl(vec_tbl),
    .shared_irq(shared_irq), .grant_out(grant_out), .vec_out(vec_out), .vec_valid(vec_valid)
  );

  task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [N-1:0] gmask(int w);
    return N'((1 << (w + 1)) - 1);
  endfunction

  task automatic raise(logic [N-1:0] m);
    @(negedge clk); req_in = m;
    @(negedge clk); req_in = '0;
    chk(shared_irq === 1'b1, "R2 shared_irq after request", shared_irq, 1);
    chk(grant_out === '0, "R3 no grant yet", grant_out, 0);
  endtask

  task automatic serve(int w);
    logic [VW-1:0] ev = vec_tbl[w*VW +: VW];
    @(negedge clk);
    chk(grant_out === gmask(w), "R4 R5 grant pattern", grant_out, gmask(w));
    chk(vec_valid === 1'b0, "R6 no strobe during grant", vec_valid, 0);
    @(negedge clk);
    chk(vec_valid === 1'b1, "R6 strobe after grant", vec_valid, 1);
    chk(vec_out === ev, "R6 captured vector", vec_out, ev);
    chk(grant_out === '0, "R8 grant dropped", grant_out, 0);
    @(negedge clk);
    chk(vec_valid === 1'b0, "R6 single pulse", vec_valid, 0);
    chk(grant_out === '0, "R8 gap cycle", grant_out, 0);
    chk(vec_out === ev, "R9 vector held", vec_out, ev);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(shared_irq === 0 && grant_out === '0 && vec_valid === 0 && vec_out === '0,
        "R1 reset state", {shared_irq, grant_out, vec_valid, vec_out}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(shared_irq === 0 && grant_out === '0 && vec_valid === 0,
        "R1 after release", {shared_irq, grant_out, vec_valid}, 0);
  endtask

  task automatic t_single;
    for (int i = 0; i < N; i++) begin
      raise(N'(1 << i));
      serve(i);
      chk(shared_irq === 1'b0, "R7 flag cleared", shared_irq, 0);
    end
  endtask

  task automatic t_multi(logic [N-1:0] m);
    raise(m);
    for (int i = 0; i < N; i++)
      if (m[i]) serve(i);
    chk(shared_irq === 1'b0, "R7 all served", shared_irq, 0);
  endtask

  task automatic t_idle_hold;
    logic [VW-1:0] last = vec_out;
    repeat (5) @(negedge clk);
    chk(vec_out === last, "R9 idle hold", vec_out, last);
    chk(grant_out === '0, "R3 no grant without request", grant_out, 0);
  endtask

  task automatic t_late_near;
    raise(4'b1000);
    @(negedge clk);
    chk(grant_out === gmask(3), "R4 full ripple to last", grant_out, gmask(3));
    req_in = 4'b0001;
    @(negedge clk); req_in = '0;
    chk(vec_out === vec_tbl[3*VW +: VW], "R6 holder captured", vec_out, vec_tbl[3*VW +: VW]);
    @(negedge clk);
    serve(0);
    chk(shared_irq === 1'b0, "R7 late request served", shared_irq, 0);
  endtask

  initial begin
    t_reset;
    t_single;
    t_multi(4'b1110);
    t_multi(4'b1111);
    t_multi(4'b1010);
    t_idle_hold;
    t_late_near;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule